// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block sits on the host side of a 12-bit sampling analog-to-digital converter that has a parallel data port. It drives the converter's control pins directly: chip select, conversion start, read strobe, shutdown and the low-power mode select. It watches the converter's busy status and reads the data bus. A client asks for a sample with a ready/valid handshake. The block selects the converter, pulses the start line, and waits until busy has dropped and then risen again. It then strobes the read line, latches the 12-bit word, and presents it as a one-cycle valid pulse with data.

Every timing rule on the pins is a whole number of system clock cycles. Each count is derived at elaboration by rounding a picosecond minimum up against the configured clock period. The rules covered are: select-to-start setup, start pulse width, read strobe width, bus release after a read, the minimum sample period, the mode-select setup before shutdown, and the wake-up time after shutdown. The client can also park the converter in a low-power state and pick nap or sleep. If the converter never finishes a conversion, a timeout counter abandons the sequence and raises an error flag.

The default clock period is 8 ns. At that period the derived counts are:

| Rule | Cycles |
|---|---|
| Select-to-start setup (`CS_CYC`) | 2 |
| Start pulse width (`START_CYC`) | 7 |
| Read strobe width (`RD_CYC`) | 6 |
| Bus release after a read (`GAP_CYC`) | 5 |
| Mode-select setup before shutdown (`MODE_CYC`) | 2 |
| Wake-up after shutdown (`WAKE_CYC`) | 25 |
| Minimum sample period (`PERIOD_CYC`) | 157 |
| Conversion timeout (`TIMEOUT_CYC`) | 320 |

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is low and after it is released, the outputs are at their reset values. `adc_cs_n`, `adc_start_n`, `adc_rd_n`, `adc_shdn_n` and `adc_napslp` are 1. `res_valid` and `timeout_err` are 0. `req_ready` is 1 once the block is idle.
- R2: `adc_cs_n` is low for exactly `CS_CYC` cycles before `adc_start_n` falls. `adc_start_n` is never low while `adc_cs_n` is high.
- R3: Each start pulse holds `adc_start_n` low for exactly `START_CYC` cycles.
- R4: `adc_rd_n` falls only after `adc_busy_n` has been seen low and then high again, at least `SYNC_STAGES` cycles after it rose. `adc_rd_n` is never low while `adc_busy_n` is low.
- R5: `adc_rd_n` is low for exactly `RD_CYC` cycles, always under a low `adc_cs_n`. In the cycle after `adc_rd_n` rises, `res_valid` is 1 for exactly one cycle. In that cycle `res_data` equals the value `adc_data` carried during the last read-low cycle.
- R6: Two consecutive falling edges of `adc_start_n` are at least `PERIOD_CYC` cycles apart.
- R7: After `adc_rd_n` rises, `adc_cs_n` stays high for at least `GAP_CYC` cycles before the next selection.
- R8: `req_ready` is 0 whenever `adc_cs_n` is low. A request held valid across several sequences yields exactly one `res_valid` pulse per accepted handshake.
- R9: With `pd_req` high in idle, `adc_napslp` takes the value of `pd_nap` (1 = nap, 0 = sleep). That value stays stable for at least `MODE_CYC` cycles before `adc_shdn_n` falls and for as long as `adc_shdn_n` is low. `adc_shdn_n` stays low while `pd_req` is high.
- R10: While `adc_shdn_n` is low, requests are ignored: `req_ready` is 0 and `adc_cs_n` stays high. After `adc_shdn_n` rises, the next falling edge of `adc_start_n` comes at least `WAKE_CYC` cycles later.
- R11: If busy has not returned high within `TIMEOUT_CYC` cycles of waiting for conversion, the block abandons the sequence. It sets `timeout_err`, produces no `res_valid`, and releases `adc_cs_n`. `timeout_err` clears on the next accepted request.
- R12: A `pd_req` raised during a conversion sequence is deferred. `adc_shdn_n` stays high until that sequence has delivered its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Sample request valid |
| req_ready | output | 1 | Block can accept a sample request |
| pd_req | input | 1 | Request to hold the converter powered down |
| pd_nap | input | 1 | Low-power mode choice: 1 nap, 0 sleep |
| res_valid | output | 1 | One-cycle pulse: `res_data` holds a new sample |
| res_data | output | 12 | Latched conversion result |
| timeout_err | output | 1 | Last conversion timed out (sticky until next accept) |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_start_n | output | 1 | Conversion start pulse, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_busy_n | input | 1 | Converter busy status, low while converting |
| adc_data | input | 12 | Converter parallel data bus |
| adc_shdn_n | output | 1 | Converter shutdown, active low |
| adc_napslp | output | 1 | Low-power mode select to converter |

## Verification
The bench runs a behavioural converter model and times every pin edge against the cycle counts above.

- **Read timing.** It drives a zero on the data bus whenever the read strobe is high. A design that latched the word too early would therefore return zero, and one that read while busy was still low would trip the busy-versus-read monitor.
- **Back-to-back requests.** Requests held valid across several sequences expose a sequencer that skips the rate limiter or accepts twice per conversion.
- **Power-down.** Power-down is entered in both modes, once with a request pending and once in the middle of a conversion. A design that let the mode pin move late, woke up too fast, or shut down mid-conversion would break the setup, wake-up or deferral check.
- **Timeout.** A conversion that never finishes within the limit must yield the error flag and no data, and the next accepted request must clear the flag.

// File: rtl/adc_seq_pkg.sv
// Package: shared state encoding and elaboration-time helpers for the
// conversion sequencer. Assumes picosecond parameters fit in a 32-bit int.
package adc_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE  = 4'd0,
        S_CSSET = 4'd1,
        S_START = 4'd2,
        S_CONV  = 4'd3,
        S_READ  = 4'd4,
        S_GAP   = 4'd5,
        S_PDSET = 4'd6,
        S_PD    = 4'd7,
        S_WAKE  = 4'd8
    } seq_state_e;

    // Round a picosecond minimum up to whole clock cycles, never below one.
    function automatic int ceil_cyc(input int ps, input int clk_ps);
        int c;
        c = (ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    // Larger of two integers.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_busy_sync.sv
// Module: brings the converter's asynchronous busy status into the clock
// domain through a chain of flops. Assumes STAGES >= 1; the reset value
// matches the idle (not busy) level.
module adc_busy_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single-flop variant: sample the pin once.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= din;
            end
        end else begin : g_multi
            // Multi-flop variant: shift the pin through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/adc_interval_timer.sv
// Module: down-counter that enforces a minimum spacing between sequence
// starts. Loading sets the count so that done returns exactly CYC cycles
// after the load. Assumes the caller loads only while done is high.
module adc_interval_timer #(
    parameter int CYC = 157
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);

    localparam int W = $clog2(CYC + 1);

    logic [W-1:0] cnt;

    // Reload on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= W'(CYC - 1);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    AST_TMR_LOAD_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> done); // R6

endmodule

// File: rtl/adc_result_reg.sv
// Module: holds the last captured sample and raises a one-cycle valid
// pulse on each capture. Assumes capture lasts a single cycle.
module adc_result_reg #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              valid
);

    // Latch the bus word and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= capture;
            if (capture) dout <= din;
        end
    end

    AST_RES_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R5

endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: top-level conversion sequencer for a parallel-output sampling
// converter. It accepts sample requests, selects the part, pulses start,
// waits for busy to complete, strobes the read line and returns the word.
// It also handles power-down entry and exit. Assumptions: one converter;
// busy is asynchronous and is synchronised here; all pin timing is derived
// from picosecond minimums at CLK_PS; the pin outputs are registered.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W        = 12,
    parameter int CLK_PS        = 8000,
    parameter int CS_SETUP_PS   = 10000,
    parameter int START_LOW_PS  = 50000,
    parameter int RD_LOW_PS     = 45000,
    parameter int BUS_REL_PS    = 40000,
    parameter int CONV_GAP_PS   = 40000,
    parameter int MODE_SETUP_PS = 10000,
    parameter int WAKE_PS       = 200000,
    parameter int PERIOD_PS     = 1250000,
    parameter int TIMEOUT_CYC   = 320,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              pd_req,
    input  logic              pd_nap,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              timeout_err,
    output logic              adc_cs_n,
    output logic              adc_start_n,
    output logic              adc_rd_n,
    input  logic              adc_busy_n,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_shdn_n,
    output logic              adc_napslp
);

    localparam int CS_CYC     = ceil_cyc(CS_SETUP_PS, CLK_PS);
    localparam int START_CYC  = ceil_cyc(START_LOW_PS, CLK_PS);
    localparam int RD_CYC     = ceil_cyc(RD_LOW_PS, CLK_PS);
    localparam int GAP_CYC    = max2(ceil_cyc(BUS_REL_PS, CLK_PS),
                                     ceil_cyc(CONV_GAP_PS, CLK_PS));
    localparam int MODE_CYC   = ceil_cyc(MODE_SETUP_PS, CLK_PS);
    localparam int WAKE_CYC   = ceil_cyc(WAKE_PS, CLK_PS);
    localparam int PERIOD_CYC = ceil_cyc(PERIOD_PS, CLK_PS);
    localparam int PH_MAX     = max2(max2(CS_CYC, START_CYC),
                                     max2(max2(RD_CYC, GAP_CYC),
                                          max2(MODE_CYC, WAKE_CYC)));
    localparam int PH_W       = $clog2(PH_MAX + 1);
    localparam int CONV_W     = $clog2(TIMEOUT_CYC + 1);

    seq_state_e        state, state_nx;
    logic [PH_W-1:0]   ph_cnt, ph_len_nx;
    logic [CONV_W-1:0] conv_cnt;
    logic              seen_low;
    logic              busy_s;
    logic              tmr_done;
    logic              accept;
    logic              conv_done;
    logic              timeout_hit;
    logic              capture;
    logic              entering;

    adc_busy_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_busy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (adc_busy_n),
        .dout  (busy_s)
    );

    adc_interval_timer #(
        .CYC (PERIOD_CYC)
    ) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .done  (tmr_done)
    );

    adc_result_reg #(
        .DATA_W (DATA_W)
    ) u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .din     (adc_data),
        .dout    (res_data),
        .valid   (res_valid)
    );

    // Handshake and phase-completion terms.
    always_comb begin
        req_ready   = (state == S_IDLE) && tmr_done && !pd_req;
        accept      = req_valid && req_ready;
        conv_done   = (state == S_CONV) && seen_low && busy_s;
        timeout_hit = (state == S_CONV) && !(seen_low && busy_s)
                      && (conv_cnt == CONV_W'(TIMEOUT_CYC - 1));
        capture     = (state == S_READ) && (ph_cnt == '0);
        entering    = (state_nx != state);
    end

    // Next-state decision for the sequencer.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (pd_req)              state_nx = S_PDSET;
                     else if (accept)         state_nx = S_CSSET;
            S_CSSET: if (ph_cnt == '0)        state_nx = S_START;
            S_START: if (ph_cnt == '0)        state_nx = S_CONV;
            S_CONV:  if (conv_done)           state_nx = S_READ;
                     else if (timeout_hit)    state_nx = S_GAP;
            S_READ:  if (ph_cnt == '0)        state_nx = S_GAP;
            S_GAP:   if (ph_cnt == '0)        state_nx = S_IDLE;
            S_PDSET: if (ph_cnt == '0)        state_nx = S_PD;
            S_PD:    if (!pd_req)             state_nx = S_WAKE;
            S_WAKE:  if (ph_cnt == '0)        state_nx = S_IDLE;
            default:                          state_nx = S_IDLE;
        endcase
    end

    // Length of the phase being entered, minus one.
    always_comb begin
        unique case (state_nx)
            S_CSSET: ph_len_nx = PH_W'(CS_CYC - 1);
            S_START: ph_len_nx = PH_W'(START_CYC - 1);
            S_READ:  ph_len_nx = PH_W'(RD_CYC - 1);
            S_GAP:   ph_len_nx = PH_W'(GAP_CYC - 1);
            S_PDSET: ph_len_nx = PH_W'(MODE_CYC - 1);
            S_WAKE:  ph_len_nx = PH_W'(WAKE_CYC - 1);
            default: ph_len_nx = '0;
        endcase
    end

    // State register and phase down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            ph_cnt <= '0;
        end else begin
            state <= state_nx;
            if (entering)           ph_cnt <= ph_len_nx;
            else if (ph_cnt != '0)  ph_cnt <= ph_cnt - 1'b1;
        end
    end

    // Conversion wait bookkeeping: elapsed cycles and busy-low observation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_cnt <= '0;
            seen_low <= 1'b0;
        end else if (entering && state_nx == S_CONV) begin
            conv_cnt <= '0;
            seen_low <= 1'b0;
        end else if (state == S_CONV) begin
            conv_cnt <= conv_cnt + 1'b1;
            if (!busy_s) seen_low <= 1'b1;
        end
    end

    // Registered converter control pins, decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_cs_n    <= 1'b1;
            adc_start_n <= 1'b1;
            adc_rd_n    <= 1'b1;
            adc_shdn_n  <= 1'b1;
        end else begin
            adc_cs_n    <= !(state_nx inside {S_CSSET, S_START, S_CONV, S_READ});
            adc_start_n <= (state_nx != S_START);
            adc_rd_n    <= (state_nx != S_READ);
            adc_shdn_n  <= (state_nx != S_PD);
        end
    end

    // Mode select: loaded from pd_nap when power-down setup begins.
    always_ff @(posedge clk) begin
        if (!rst_n)                            adc_napslp <= 1'b1;
        else if (entering && state_nx == S_PDSET) adc_napslp <= pd_nap;
    end

    // Sticky timeout flag, cleared by the next accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)           timeout_err <= 1'b0;
        else if (accept)      timeout_err <= 1'b0;
        else if (timeout_hit) timeout_err <= 1'b1;
    end

    AST_START_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_start_n |-> !adc_cs_n); // R2
    AST_READ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_rd_n) |-> $past(busy_s)); // R4
    AST_RD_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> !adc_cs_n); // R5
    AST_RESULT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(!adc_rd_n)); // R5
    AST_NO_READY_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n |-> !req_ready); // R8
    AST_MODE_HELD_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_shdn_n |-> $stable(adc_napslp)); // R9
    AST_NO_READY_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_shdn_n |-> (!req_ready && adc_cs_n)); // R10
    AST_ERR_FROM_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> $past(state == S_CONV)); // R11

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

    localparam int CS_CYC     = 2;
    localparam int START_CYC  = 7;
    localparam int RD_CYC     = 6;
    localparam int GAP_CYC    = 5;
    localparam int MODE_CYC   = 2;
    localparam int WAKE_CYC   = 25;
    localparam int PERIOD_CYC = 157;
    localparam int SYNC_CYC   = 2;

    // Vector: {expect timeout, bus word, converter busy-low cycles}
    localparam int NVEC = 6;
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b0, 12'h000, 10'd60},
        {1'b0, 12'hFFF, 10'd150},
        {1'b0, 12'hA5A, 10'd90},
        {1'b0, 12'h5A5, 10'd20},
        {1'b1, 12'h800, 10'd600},
        {1'b0, 12'h7FF, 10'd100}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        pd_req = 1'b0;
    logic        pd_nap = 1'b1;
    logic        res_valid;
    logic [11:0] res_data;
    logic        timeout_err;
    logic        adc_cs_n, adc_start_n, adc_rd_n, adc_shdn_n, adc_napslp;
    logic        adc_busy_n = 1'b1;
    logic [11:0] adc_data;
    logic [11:0] m_data = 12'h000;
    int          m_conv = 50;

    int checks = 0, bad = 0;
    int mon_chk = 0, mon_bad = 0;

    always #4 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .pd_req(pd_req), .pd_nap(pd_nap), .res_valid(res_valid),
        .res_data(res_data), .timeout_err(timeout_err), .adc_cs_n(adc_cs_n),
        .adc_start_n(adc_start_n), .adc_rd_n(adc_rd_n), .adc_busy_n(adc_busy_n),
        .adc_data(adc_data), .adc_shdn_n(adc_shdn_n), .adc_napslp(adc_napslp)
    );

    // Converter model: bus driven only while read strobe is low.
    assign adc_data = adc_rd_n ? 12'h000 : m_data;

    int m_dly = 0, m_left = 0;
    logic m_pstart = 1'b1;
    always @(negedge clk) begin
        if (m_pstart && !adc_start_n) m_dly = 2;
        m_pstart = adc_start_n;
        if (m_dly > 0) begin
            m_dly = m_dly - 1;
            if (m_dly == 0) begin adc_busy_n = 1'b0; m_left = m_conv; end
        end else if (m_left > 0) begin
            m_left = m_left - 1;
            if (m_left == 0) adc_busy_n = 1'b1;
        end
    end

    task automatic mchk(input bit ok, input string req, input int act, input int exp);
        mon_chk++;
        if (!ok) begin
            mon_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Pin timing monitor.
    logic p_cs = 1, p_st = 1, p_rd = 1, p_sh = 1, p_nap = 1;
    int cs_pre = 0, st_w = 0, rd_w = 0, busy_hi = 0, nap_st = 0;
    int s2s = 0, gap = 0, wk = 0;
    bit s2s_arm = 0, gap_arm = 0, wk_arm = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            p_cs = 1; p_st = 1; p_rd = 1; p_sh = 1; p_nap = adc_napslp;
            s2s_arm = 0; gap_arm = 0; wk_arm = 0;
        end else begin
            s2s++; gap++; wk++;
            busy_hi = adc_busy_n ? busy_hi + 1 : 0;
            nap_st = (adc_napslp != p_nap) ? 0 : nap_st + 1;
            if (!adc_cs_n && adc_start_n) cs_pre++;
            else if (adc_cs_n) cs_pre = 0;
            if (p_cs && !adc_cs_n) begin
                mchk(!req_ready, "R8 ready while selected", req_ready, 0);
                if (gap_arm) mchk(gap >= GAP_CYC + 1, "R7 rd-rise to cs-fall", gap, GAP_CYC + 1);
            end
            if (p_st && !adc_start_n) begin
                mchk(cs_pre == CS_CYC, "R2 cs setup", cs_pre, CS_CYC);
                if (s2s_arm) mchk(s2s >= PERIOD_CYC, "R6 start spacing", s2s, PERIOD_CYC);
                if (wk_arm) mchk(wk >= WAKE_CYC, "R10 wake time", wk, WAKE_CYC);
                s2s = 0; s2s_arm = 1; wk_arm = 0; cs_pre = 0;
            end
            if (!adc_start_n) st_w++;
            if (!p_st && adc_start_n) begin
                mchk(st_w == START_CYC, "R3 start width", st_w, START_CYC);
                st_w = 0;
            end
            if (p_rd && !adc_rd_n)
                mchk(busy_hi >= SYNC_CYC, "R4 read after busy", busy_hi, SYNC_CYC);
            if (!adc_rd_n) rd_w++;
            if (!p_rd && adc_rd_n) begin
                mchk(rd_w == RD_CYC, "R5 rd width", rd_w, RD_CYC);
                rd_w = 0; gap = 0; gap_arm = 1;
            end
            if (p_sh && !adc_shdn_n) begin
                mchk(nap_st >= MODE_CYC, "R9 mode setup", nap_st, MODE_CYC);
                mchk(adc_napslp == pd_nap, "R9 mode value", adc_napslp, pd_nap);
            end
            if (!p_sh && adc_shdn_n) begin wk = 0; wk_arm = 1; end
            p_cs = adc_cs_n; p_st = adc_start_n; p_rd = adc_rd_n;
            p_sh = adc_shdn_n; p_nap = adc_napslp;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic send_req();
        @(negedge clk);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Wait for a result pulse or a timeout flag; returns 1 for a result.
    task automatic wait_done(output bit got_res, output bit got_err);
        got_res = 0; got_err = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (res_valid) begin got_res = 1; break; end
            if (timeout_err) begin got_err = 1; break; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks + mon_chk + 1, bad + mon_bad + 1);
        $finish;
    end

    initial begin
        bit gr, ge;
        int acc, nres;
        // R1: reset values, during and after reset
        repeat (4) @(negedge clk);
        chk(adc_cs_n && adc_start_n && adc_rd_n && adc_shdn_n && adc_napslp,
            "R1 pins in reset", {adc_cs_n, adc_start_n, adc_rd_n, adc_shdn_n, adc_napslp}, 5'h1F);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!res_valid && !timeout_err && req_ready, "R1 idle after reset",
            {res_valid, timeout_err, req_ready}, 3'b001);

        // Table walk: R5 data capture, R11 timeout
        for (int v = 0; v < NVEC; v++) begin
            m_data = VEC[v][21:10];
            m_conv = int'(VEC[v][9:0]);
            send_req();
            if (v == 5) chk(!timeout_err, "R11 flag cleared by accept", timeout_err, 0);
            wait_done(gr, ge);
            if (VEC[v][22]) begin
                chk(ge && !gr, "R11 timeout flagged", {gr, ge}, 2'b01);
                @(negedge clk);
                chk(adc_cs_n && !res_valid, "R11 cs released, no result", {adc_cs_n, res_valid}, 2'b10);
                while (!adc_busy_n) @(negedge clk);
            end else begin
                chk(gr && res_data == VEC[v][21:10], "R5 result word", res_data, VEC[v][21:10]);
                chk(!timeout_err, "R11 no flag on good conversion", timeout_err, 0);
                @(negedge clk);
                chk(!res_valid, "R5 single pulse", res_valid, 0);
            end
        end

        // R8: held request, one result per accept
        m_conv = 50; m_data = 12'h3C3; acc = 0; nres = 0;
        @(negedge clk);
        req_valid = 1'b1;
        for (int i = 0; i < 500; i++) begin
            if (i == 499) req_valid = 1'b0;
            else if (req_ready) acc++;
            if (res_valid) nres++;
            @(negedge clk);
        end
        for (int i = 0; i < 400; i++) begin
            if (res_valid) nres++;
            @(negedge clk);
        end
        chk(acc >= 3, "R8 several accepts under rate limit", acc, 3);
        chk(nres == acc, "R8 results per accept", nres, acc);

        // R9/R10: nap mode with a pending request
        pd_nap = 1'b1; pd_req = 1'b1;
        repeat (8) @(negedge clk);
        req_valid = 1'b1;
        repeat (10) @(negedge clk);
        chk(!adc_shdn_n && adc_napslp, "R9 nap shutdown", {adc_shdn_n, adc_napslp}, 2'b01);
        chk(!req_ready && adc_cs_n, "R10 request ignored in shutdown", {req_ready, adc_cs_n}, 2'b01);
        m_data = 12'h1E1;
        pd_req = 1'b0;
        while (adc_cs_n) @(negedge clk);
        req_valid = 1'b0;
        wait_done(gr, ge);
        chk(gr && res_data == 12'h1E1, "R10 sample after wake", res_data, 12'h1E1);

        // R9: sleep mode
        pd_nap = 1'b0; pd_req = 1'b1;
        repeat (12) @(negedge clk);
        chk(!adc_shdn_n && !adc_napslp, "R9 sleep shutdown", {adc_shdn_n, adc_napslp}, 2'b00);
        pd_req = 1'b0;
        repeat (40) @(negedge clk);
        chk(adc_shdn_n, "R9 shutdown released", adc_shdn_n, 1);

        // R12: power-down raised mid-conversion is deferred
        m_data = 12'h456; pd_nap = 1'b1;
        send_req();
        pd_req = 1'b1;
        gr = 0; acc = 0;
        for (int i = 0; i < 3000 && !gr; i++) begin
            @(negedge clk);
            if (!adc_shdn_n) acc++;
            if (res_valid) gr = 1;
        end
        chk(gr && acc == 0, "R12 no shutdown before result", acc, 0);
        chk(res_data == 12'h456, "R12 result word", res_data, 12'h456);
        repeat (15) @(negedge clk);
        chk(!adc_shdn_n, "R12 shutdown after sequence", adc_shdn_n, 0);
        pd_req = 1'b0;
        m_data = 12'h9AB;
        send_req();
        wait_done(gr, ge);
        chk(gr && res_data == 12'h9AB, "R10 sample after second wake", res_data, 12'h9AB);
        repeat (10) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", checks + mon_chk, bad + mon_bad);
        $finish;
    end

endmodule